// File: doc/BRIEF.md
# Latency-Countdown Issue Queue with Operand Precheck

This block holds renamed instructions that wait to be sent to the functional units. It has no tag broadcast and no comparators. Each entry instead carries a predicted-latency counter that is loaded at dispatch and counts down by one every cycle. When an entry's counter is zero, the entry looks up the ready bits of its two source registers in a small scoreboard inside the block. It asks for an issue slot only when both bits are set. An entry that fails this lookup keeps its place in the queue and looks again on the next cycle. Because of this, an issue slot never goes to an instruction whose operands are still missing.

A selector grants up to four requests each cycle, oldest first. The granted entries leave the queue. The remaining entries shift down so that index 0 always holds the oldest instruction. Newly dispatched instructions are appended behind the survivors, with dispatch lane 0 ahead of lane 1. Issuing an instruction clears the ready bit of its destination register. A write-back port sets that bit again.

Top module: `wf_issue_queue`

## Requirements
- R1: After reset the queue is empty, no issue lane is valid, the dispatch stall is low, and every register ready bit is set. An instruction with latency 0 that reads any register therefore issues in the first cycle after it is accepted.
- R2: An instruction accepted at clock edge E with latency L, whose sources are ready, appears on an issue lane in the cycle that follows edge E+L, and never earlier.
- R3: An entry whose counter is zero issues only while the ready bits of both of its sources are set. Otherwise it stays in the queue and retries every cycle, and it issues in the cycle after the edge at which write-back sets the missing bit.
- R4: At most ISSUE_W (4) instructions issue per cycle. The valid lanes are packed from lane 0 upward.
- R5: When more entries request than there are lanes, the oldest requesters take the lanes. Lane 0 carries the oldest of them, and the rest issue in later cycles.
- R6: Issued entries leave the queue at the issue edge. Survivors keep their relative age, and the freed slots become available to new dispatches.
- R7: The dispatch stall output is high when the number of valid dispatch lanes exceeds the number of free entries. While it is high, no lane is accepted.
- R8: Issuing an instruction clears its destination's ready bit at the issue edge, and a write-back sets the bit. If both target the same register at the same edge, the clear wins.
- R9: Two instructions accepted at the same edge are ordered with dispatch lane 0 older than lane 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | DISP_W | Per-lane dispatch valid |
| disp_op_i | input | DISP_W x OP_W | Opcode payload per lane |
| disp_src0_i | input | DISP_W x TAG_W | First source register tag |
| disp_src1_i | input | DISP_W x TAG_W | Second source register tag |
| disp_dst_i | input | DISP_W x TAG_W | Destination register tag |
| disp_lat_i | input | DISP_W x LAT_W | Predicted cycles until operands arrive |
| disp_stall_o | output | 1 | High when the offered lanes do not fit |
| wb_valid_i | input | WB_N | Write-back valid, sets a ready bit |
| wb_tag_i | input | WB_N x TAG_W | Register tag being written back |
| issue_valid_o | output | ISSUE_W | Per-lane issue valid |
| issue_op_o | output | ISSUE_W x OP_W | Issued opcode payload |
| issue_src0_o | output | ISSUE_W x TAG_W | Issued first source tag |
| issue_src1_o | output | ISSUE_W x TAG_W | Issued second source tag |
| issue_dst_o | output | ISSUE_W x TAG_W | Issued destination tag |

## Verification
The bench builds the block with its defaults: DEPTH=8, ISSUE_W=4, DISP_W=2, WB_N=2, a 5-bit tag and a 3-bit latency. Eight entries against four lanes is small enough to fill the queue in four dispatch cycles. That reaches the stall and the point where one slot is free but two lanes are offered. It also lets six zero-latency requesters arise together, so the selector must defer two of them to the next cycle. The 3-bit latency covers the full countdown range, up to 7, within a short table walk.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int OP_W  = 8;
  localparam int TAG_W = 5;
  localparam int LAT_W = 3;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] src0;
    logic [TAG_W-1:0] src1;
    logic [TAG_W-1:0] dst;
    logic [LAT_W-1:0] lat;
  } wf_entry_t;
endpackage

// File: rtl/wf_ready_table.sv
module wf_ready_table #(
  parameter int NREG    = 32,
  parameter int ISSUE_W = 4,
  parameter int WB_N    = 2,
  localparam int TW     = $clog2(NREG)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [WB_N-1:0]              set_vld_i,
  input  logic [WB_N-1:0][TW-1:0]      set_tag_i,
  input  logic [ISSUE_W-1:0]           clr_vld_i,
  input  logic [ISSUE_W-1:0][TW-1:0]   clr_tag_i,
  output logic [NREG-1:0]              rdy_o
);
  logic [NREG-1:0] rdy_q, rdy_d;

  // sets applied first so a same-edge clear wins
  always_comb begin
    rdy_d = rdy_q;
    for (int w = 0; w < WB_N; w++)
      if (set_vld_i[w]) rdy_d[set_tag_i[w]] = 1'b1;
    for (int k = 0; k < ISSUE_W; k++)
      if (clr_vld_i[k]) rdy_d[clr_tag_i[k]] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= '1;
    else         rdy_q <= rdy_d;
  end

  assign rdy_o = rdy_q;

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_clr_chk
    // R8
    clear_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_vld_i[k] |=> !rdy_q[$past(clr_tag_i[k])]);
  end
endmodule

// File: rtl/wf_age_select.sv
module wf_age_select #(
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 4,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [DEPTH-1:0]                req_i,
  output logic [DEPTH-1:0]                grant_o,
  output logic [ISSUE_W-1:0]              lane_vld_o,
  output logic [ISSUE_W-1:0][IDX_W-1:0]   lane_idx_o
);
  // index 0 is oldest: a forward scan gives age priority
  always_comb begin
    int n;
    n          = 0;
    grant_o    = '0;
    lane_vld_o = '0;
    lane_idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (req_i[i] && n < ISSUE_W) begin
        grant_o[i]    = 1'b1;
        lane_vld_o[n] = 1'b1;
        lane_idx_o[n] = IDX_W'(i);
        n++;
      end
    end
  end

  for (genvar k = 1; k < ISSUE_W; k++) begin : g_age_chk
    // R5
    lane_age_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_vld_o[k] |-> (lane_idx_o[k] > lane_idx_o[k-1]));
  end
endmodule

// File: rtl/wf_store.sv
module wf_store
  import wf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DISP_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DEPTH-1:0]              grant_i,
  input  logic                          acc_i,
  input  logic [DISP_W-1:0]             disp_vld_i,
  input  wf_entry_t [DISP_W-1:0]        disp_ent_i,
  output wf_entry_t [DEPTH-1:0]         ent_o,
  output logic [DEPTH-1:0]              vld_o
);
  wf_entry_t [DEPTH-1:0] ent_q, ent_d;
  logic [DEPTH-1:0]      vld_q, vld_d;

  always_comb begin
    int k;
    k     = 0;
    ent_d = '0;
    vld_d = '0;
    // survivors compact toward index 0, counters tick down
    for (int i = 0; i < DEPTH; i++) begin
      if (vld_q[i] && !grant_i[i] && k < DEPTH) begin
        ent_d[k] = ent_q[i];
        if (ent_q[i].lat != '0) ent_d[k].lat = ent_q[i].lat - 1'b1;
        vld_d[k] = 1'b1;
        k++;
      end
    end
    // new arrivals behind survivors, lane 0 first
    if (acc_i) begin
      for (int d = 0; d < DISP_W; d++) begin
        if (disp_vld_i[d] && k < DEPTH) begin
          ent_d[k] = disp_ent_i[d];
          vld_d[k] = 1'b1;
          k++;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
      vld_q <= '0;
    end else begin
      ent_q <= ent_d;
      vld_q <= vld_d;
    end
  end

  assign ent_o = ent_q;
  assign vld_o = vld_q;

  // R6
  packed_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((vld_q + 1'b1) & vld_q) == '0);
endmodule

// File: rtl/wf_issue_queue.sv
module wf_issue_queue
  import wf_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int ISSUE_W = 4,
  parameter int DISP_W  = 2,
  parameter int WB_N    = 2,
  localparam int NREG   = 1 << TAG_W,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [DISP_W-1:0]                 disp_valid_i,
  input  logic [DISP_W-1:0][OP_W-1:0]       disp_op_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]      disp_src0_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]      disp_src1_i,
  input  logic [DISP_W-1:0][TAG_W-1:0]      disp_dst_i,
  input  logic [DISP_W-1:0][LAT_W-1:0]      disp_lat_i,
  output logic                              disp_stall_o,
  input  logic [WB_N-1:0]                   wb_valid_i,
  input  logic [WB_N-1:0][TAG_W-1:0]        wb_tag_i,
  output logic [ISSUE_W-1:0]                issue_valid_o,
  output logic [ISSUE_W-1:0][OP_W-1:0]      issue_op_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0]     issue_src0_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0]     issue_src1_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0]     issue_dst_o
);
  wf_entry_t [DEPTH-1:0]          ent;
  wf_entry_t [DISP_W-1:0]         disp_ent;
  logic [DEPTH-1:0]               vld, req, grant;
  logic [NREG-1:0]                rdy;
  logic [ISSUE_W-1:0]             lane_vld;
  logic [ISSUE_W-1:0][IDX_W-1:0]  lane_idx;
  logic [ISSUE_W-1:0][TAG_W-1:0]  clr_tag;
  logic                           acc;
  int                             occ_n, in_n;

  always_comb begin
    for (int d = 0; d < DISP_W; d++) begin
      disp_ent[d].op   = disp_op_i[d];
      disp_ent[d].src0 = disp_src0_i[d];
      disp_ent[d].src1 = disp_src1_i[d];
      disp_ent[d].dst  = disp_dst_i[d];
      disp_ent[d].lat  = disp_lat_i[d];
    end
  end

  // all-or-none acceptance of the dispatch group
  always_comb begin
    occ_n = 0;
    in_n  = 0;
    for (int i = 0; i < DEPTH; i++)  if (vld[i]) occ_n++;
    for (int d = 0; d < DISP_W; d++) if (disp_valid_i[d]) in_n++;
  end
  assign disp_stall_o = in_n > (DEPTH - occ_n);
  assign acc          = (in_n != 0) && !disp_stall_o;

  // precheck: zero count gated by both source ready bits
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      req[i] = vld[i] && (ent[i].lat == '0) && rdy[ent[i].src0] && rdy[ent[i].src1];
  end

  wf_store #(.DEPTH(DEPTH), .DISP_W(DISP_W)) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant),
    .acc_i      (acc),
    .disp_vld_i (disp_valid_i),
    .disp_ent_i (disp_ent),
    .ent_o      (ent),
    .vld_o      (vld)
  );

  wf_age_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) i_select (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .grant_o    (grant),
    .lane_vld_o (lane_vld),
    .lane_idx_o (lane_idx)
  );

  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) begin
      issue_valid_o[k] = lane_vld[k];
      issue_op_o[k]    = ent[lane_idx[k]].op;
      issue_src0_o[k]  = ent[lane_idx[k]].src0;
      issue_src1_o[k]  = ent[lane_idx[k]].src1;
      issue_dst_o[k]   = ent[lane_idx[k]].dst;
      clr_tag[k]       = ent[lane_idx[k]].dst;
    end
  end

  wf_ready_table #(.NREG(NREG), .ISSUE_W(ISSUE_W), .WB_N(WB_N)) i_ready (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_vld_i (wb_valid_i),
    .set_tag_i (wb_tag_i),
    .clr_vld_i (lane_vld),
    .clr_tag_i (clr_tag),
    .rdy_o     (rdy)
  );

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_issue_chk
    // R3
    src_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_valid_o[k] |-> (rdy[issue_src0_o[k]] && rdy[issue_src1_o[k]]));
    // R2
    count_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      issue_valid_o[k] |-> (ent[lane_idx[k]].lat == '0));
    if (k > 0) begin : g_pack
      // R4
      lane_pack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_valid_o[k] |-> issue_valid_o[k-1]);
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_stall_o |=> (occ_n <= $past(occ_n)));
endmodule

// File: tb/test_wf_issue_queue.sv
module test_wf_issue_queue;
  import wf_pkg::*;
  localparam int DEPTH = 8, ISSUE_W = 4, DISP_W = 2, WB_N = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [DISP_W-1:0]              disp_valid_i;
  logic [DISP_W-1:0][OP_W-1:0]    disp_op_i;
  logic [DISP_W-1:0][TAG_W-1:0]   disp_src0_i, disp_src1_i, disp_dst_i;
  logic [DISP_W-1:0][LAT_W-1:0]   disp_lat_i;
  logic                           disp_stall_o;
  logic [WB_N-1:0]                wb_valid_i;
  logic [WB_N-1:0][TAG_W-1:0]     wb_tag_i;
  logic [ISSUE_W-1:0]             issue_valid_o;
  logic [ISSUE_W-1:0][OP_W-1:0]   issue_op_o;
  logic [ISSUE_W-1:0][TAG_W-1:0]  issue_src0_o, issue_src1_o, issue_dst_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  wf_issue_queue #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .DISP_W(DISP_W), .WB_N(WB_N)) i_wf_issue_queue (
    .clk_i, .rst_ni, .disp_valid_i, .disp_op_i, .disp_src0_i, .disp_src1_i,
    .disp_dst_i, .disp_lat_i, .disp_stall_o, .wb_valid_i, .wb_tag_i,
    .issue_valid_o, .issue_op_o, .issue_src0_o, .issue_src1_o, .issue_dst_o
  );

  // table: {latency, destination tag, expected cycles after acceptance}
  localparam int VEC [6][3] = '{'{0, 16, 0}, '{3, 17, 3}, '{7, 18, 7},
                                '{1, 19, 1}, '{5, 20, 5}, '{2, 21, 2}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic idle_in();
    disp_valid_i = '0; disp_op_i = '0; disp_src0_i = '0; disp_src1_i = '0;
    disp_dst_i = '0; disp_lat_i = '0; wb_valid_i = '0; wb_tag_i = '0;
  endtask

  task automatic lane(input int d, input int op, input int s0, input int s1, input int dst, input int lat);
    disp_valid_i[d] = 1'b1;
    disp_op_i[d]    = OP_W'(op);
    disp_src0_i[d]  = TAG_W'(s0);
    disp_src1_i[d]  = TAG_W'(s1);
    disp_dst_i[d]   = TAG_W'(dst);
    disp_lat_i[d]   = LAT_W'(lat);
  endtask

  task automatic wb(input int tag);
    wb_valid_i[0] = 1'b1;
    wb_tag_i[0]   = TAG_W'(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog act=0 exp=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int w;
    idle_in();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    #1;
    // R1 reset state
    chk(issue_valid_o == '0, "R1 issue idle", int'(issue_valid_o), 0);
    chk(disp_stall_o == 1'b0, "R1 stall low", int'(disp_stall_o), 0);
    // R1 ready bits all set: high tags read at once
    lane(0, 8'h11, 31, 30, 29, 0); tick(); idle_in();
    chk(issue_valid_o == 4'b0001, "R1 ready at reset", int'(issue_valid_o), 1);
    chk(issue_op_o[0] == 8'h11, "R1 op", int'(issue_op_o[0]), 8'h11);
    tick();

    // R2 countdown table
    for (int i = 0; i < 6; i++) begin
      lane(0, 8'h40 + i, 1, 2, VEC[i][1], VEC[i][0]); tick(); idle_in();
      w = 0;
      while (!issue_valid_o[0] && w < 12) begin tick(); w++; end
      chk(w == VEC[i][2], "R2 issue delay", w, VEC[i][2]);
      chk(issue_op_o[0] == OP_W'(8'h40 + i) && issue_dst_o[0] == TAG_W'(VEC[i][1]),
          "R2 issued entry", int'(issue_dst_o[0]), VEC[i][1]);
      tick();
      chk(issue_valid_o == '0, "R6 entry removed", int'(issue_valid_o), 0);
    end

    // R3/R8: producer clears r10, consumer waits until write-back
    lane(0, 8'h50, 1, 2, 10, 0); tick(); idle_in();
    chk(issue_valid_o[0] && issue_dst_o[0] == 5'd10, "R8 producer issues", int'(issue_valid_o), 1);
    lane(0, 8'h51, 10, 1, 22, 0); tick(); idle_in();
    for (int c = 0; c < 3; c++) begin
      chk(issue_valid_o == '0, "R3 held by precheck", int'(issue_valid_o), 0);
      tick();
    end
    wb(10); tick(); idle_in();
    chk(issue_valid_o == 4'b0001 && issue_op_o[0] == 8'h51, "R3 issue after write-back",
        int'(issue_op_o[0]), 8'h51);
    tick();

    // R8 clear wins over same-edge write-back
    lane(0, 8'h60, 1, 2, 11, 0); tick(); idle_in();
    chk(issue_valid_o[0] && issue_dst_o[0] == 5'd11, "R8 producer 11", int'(issue_dst_o[0]), 11);
    wb(11); lane(0, 8'h61, 1, 11, 23, 0); tick(); idle_in();
    chk(issue_valid_o == '0, "R8 clear wins", int'(issue_valid_o), 0);
    tick();
    chk(issue_valid_o == '0, "R8 still clear", int'(issue_valid_o), 0);
    wb(11); tick(); idle_in();
    chk(issue_valid_o == 4'b0001 && issue_op_o[0] == 8'h61, "R8 set by write-back",
        int'(issue_op_o[0]), 8'h61);
    tick();

    // R4/R5/R9: six requesters align in one cycle
    lane(0, 1, 1, 2, 13, 2); lane(1, 2, 1, 2, 14, 2); tick(); idle_in();
    chk(issue_valid_o == '0, "R2 pair A waits", int'(issue_valid_o), 0);
    lane(0, 3, 1, 2, 15, 1); lane(1, 4, 1, 2, 16, 1); tick(); idle_in();
    chk(issue_valid_o == '0, "R2 pairs wait", int'(issue_valid_o), 0);
    lane(0, 5, 1, 2, 17, 0); lane(1, 6, 1, 2, 18, 0); tick(); idle_in();
    chk(issue_valid_o == 4'b1111, "R4 four lanes", int'(issue_valid_o), 15);
    for (int k = 0; k < 4; k++)
      chk(issue_op_o[k] == OP_W'(k + 1), "R5 oldest first / R9 lane order", int'(issue_op_o[k]), k + 1);
    tick();
    chk(issue_valid_o == 4'b0011, "R4 packed remainder", int'(issue_valid_o), 3);
    chk(issue_op_o[0] == 8'd5 && issue_op_o[1] == 8'd6, "R6 survivors keep order",
        int'(issue_op_o[0]), 5);
    tick();
    chk(issue_valid_o == '0, "R6 queue drained", int'(issue_valid_o), 0);

    // R7 stall: block r12, fill the queue
    lane(0, 8'h70, 1, 2, 12, 0); tick(); idle_in();
    tick();
    for (int p = 0; p < 3; p++) begin
      lane(0, 8'h80 + 2*p, 12, 1, 24 + 2*p, 0); lane(1, 8'h81 + 2*p, 12, 1, 25 + 2*p, 0);
      #1 chk(disp_stall_o == 1'b0, "R7 room for pair", int'(disp_stall_o), 0);
      tick(); idle_in();
    end
    lane(0, 8'h86, 12, 1, 30, 0); tick(); idle_in();
    lane(0, 8'hE0, 12, 1, 3, 0); lane(1, 8'hE1, 12, 1, 4, 0);
    #1 chk(disp_stall_o == 1'b1, "R7 two lanes one slot", int'(disp_stall_o), 1);
    tick(); idle_in();
    lane(0, 8'h87, 12, 1, 31, 0);
    #1 chk(disp_stall_o == 1'b0, "R7 single fits", int'(disp_stall_o), 0);
    tick(); idle_in();
    lane(0, 8'hE2, 1, 2, 5, 0);
    #1 chk(disp_stall_o == 1'b1, "R7 full queue", int'(disp_stall_o), 1);
    tick(); idle_in();
    chk(issue_valid_o == '0, "R3 all blocked", int'(issue_valid_o), 0);
    wb(12); tick(); idle_in();
    chk(issue_valid_o == 4'b1111, "R5 first four", int'(issue_valid_o), 15);
    for (int k = 0; k < 4; k++)
      chk(issue_op_o[k] == OP_W'(8'h80 + k), "R5 age order", int'(issue_op_o[k]), 8'h80 + k);
    tick();
    chk(issue_valid_o == 4'b1111, "R6 next four", int'(issue_valid_o), 15);
    for (int k = 0; k < 4; k++)
      chk(issue_op_o[k] == OP_W'(8'h84 + k), "R6 age order", int'(issue_op_o[k]), 8'h84 + k);
    tick();
    chk(issue_valid_o == '0, "R7 stalled lanes not queued", int'(issue_valid_o), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule